// File: doc/BRIEF.md
# Multiplexed Serial ADC Sequencer

This block scans an external 8-input analog multiplexer that feeds a 12-bit serial sampling converter. For each channel it sets the 3-bit multiplexer select and waits a programmable number of system clocks so the analog path can settle. It then lowers the converter chip select and runs a serial clock, divided down from the system clock, while it shifts in a two's-complement result most significant bit first. Each finished sample goes out as one word that carries the channel number and the 12-bit code.

Channel assignment is fixed. Inputs 0 and 1 carry the two pressure signals. Inputs 2 and 3 are the transducer disconnect monitors. Inputs 4 to 7 are supply taps. A set bit in the enable mask includes a channel in the round-robin scan, and a level `run` input starts and stops the scan. On the two monitor channels, a reading at or above a programmable signed threshold means an unplugged transducer. The threshold is normally set just below positive full scale (0x7FF). The matching flag changes state only after two consecutive scans agree.

The result port follows valid/ready rules. A word stays stable while `res_valid` is high and `res_ready` is low. A new word never overwrites one that has not been accepted: the finished conversion waits with chip select high until the slot frees, and the scan stalls with it. A typical setting is a settling count of 16 and a divider that gives about 410 kHz.

Top module: `adcseq_top`

## Requirements
- R1: While reset is held, `adc_cs_n` and `adc_sclk` are 1, `adc_mux_sel` is 0, `res_valid` is 0 and `disc_flag` is 0.
- R2: Each new conversion uses the first channel whose `ch_en` bit is set, searching upward (with wraparound) from the channel converted last. The search after reset starts at channel 0. Disabled channels are never converted.
- R3: `adc_mux_sel` changes only while `adc_cs_n` is high. Before each falling edge of `adc_cs_n`, the chip select stays high for at least `settle_cycles`+1 system clocks.
- R4: The serial clock idles at 1 whenever `adc_cs_n` is high. During a conversion it toggles every `clk_div` system clocks (a value of 0 acts as 1), and the first toggle after chip select falls is a falling edge. The data bit is sampled at each rising edge, most significant bit first, and the 12 bits form `res_code`.
- R5: `adc_cs_n` rises on the same system clock edge as the 12th rising serial-clock edge, and it stays high for at least one clock afterwards.
- R6: Each conversion yields exactly one word, in conversion order. `res_chan` is the channel that was selected and `res_code` is the sampled code. While `res_valid`=1 and `res_ready`=0, the word holds stable and `res_valid` stays 1.
- R7: `disc_flag[0]` follows channel 2 and `disc_flag[1]` follows channel 3. A sample is a hit when the code, taken as signed, is greater than or equal to the signed `disc_thresh`. The flag becomes 1 after two consecutive hits on its channel and 0 after two consecutive non-hits. Samples from other channels leave it unchanged.
- R8: With `run` low, or with `ch_en` all zero, no new conversion starts and `adc_cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Scan runs while high; the current conversion completes when it drops |
| ch_en | input | 8 | Per-channel scan enable |
| settle_cycles | input | 16 | Settling wait after select, in system clocks |
| clk_div | input | 8 | Serial clock half-period, in system clocks |
| disc_thresh | input | 12 | Signed hit threshold for the disconnect monitors |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_mux_sel | output | 3 | Analog multiplexer select |
| adc_sdata | input | 1 | Converter serial data |
| res_valid | output | 1 | Result word valid |
| res_ready | input | 1 | Consumer accepts the word |
| res_chan | output | 3 | Channel tag of the word |
| res_code | output | 12 | Two's-complement sample |
| disc_flag | output | 2 | Disconnect state of monitor channels 2 and 3 |

## Verification
The assertions assume that `ch_en`, `settle_cycles`, `clk_div` and `disc_thresh` stay constant while a scan is running. The checks on the enabled channel and on the settling gap compare against the current values of these inputs. The stimulus changes configuration only after it has dropped `run`, waited out any conversion in flight and drained the result slot. The stimulus randomizes back-pressure on every cycle, so stalls also fall on completing conversions.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;
  localparam int CH_W     = 3;
  localparam int NCH      = 1 << CH_W;
  localparam int SAMPLE_W = 12;
  localparam int NMON     = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CONV,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/adcseq_rr_pick.sv
`timescale 1ns/1ps
module adcseq_rr_pick #(
  parameter int CH_W = 3,
  localparam int NCH = 1 << CH_W
) (
  input  logic [CH_W-1:0] last,
  input  logic [NCH-1:0]  en,
  output logic            any,
  output logic [CH_W-1:0] pick
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= NCH; k++) begin
      logic [CH_W-1:0] cand;
      cand = last + CH_W'(k);
      if (!found && en[cand]) begin
        pick  = cand;
        found = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/adcseq_serial_rx.sv
`timescale 1ns/1ps
module adcseq_serial_rx #(
  parameter int DATA_W = 12,
  parameter int DIV_W  = 8,
  localparam int TOG_TOTAL = 2 * DATA_W,
  localparam int TOG_W = $clog2(TOG_TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [DIV_W-1:0]  div,
  input  logic              sdata,
  output logic              sclk,
  output logic              done,
  output logic [DATA_W-1:0] word
);
  logic [DIV_W-1:0]  div_cnt;
  logic [DIV_W-1:0]  div_last;
  logic [TOG_W-1:0]  tog;
  logic              sclk_q;
  logic [DATA_W-1:0] sh;
  logic              edge_now;

  assign div_last = (div == '0) ? '0 : div - DIV_W'(1);
  assign edge_now = active && (div_cnt == div_last);
  assign done     = edge_now && (tog == TOG_W'(TOG_TOTAL - 1));
  assign sclk     = sclk_q;
  assign word     = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tog     <= '0;
      sclk_q  <= 1'b1;
      sh      <= '0;
    end else if (!active) begin
      div_cnt <= '0;
      tog     <= '0;
      sclk_q  <= 1'b1;
    end else if (edge_now) begin
      div_cnt <= '0;
      tog     <= tog + TOG_W'(1);
      sclk_q  <= ~sclk_q;
      if (!sclk_q) sh <= {sh[DATA_W-2:0], sdata};
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/adcseq_disc_track.sv
`timescale 1ns/1ps
module adcseq_disc_track #(
  parameter int NMON   = 2,
  parameter int CH_W   = 3,
  parameter int DATA_W = 12,
  parameter logic [NMON*CH_W-1:0] MON_CHS = {3'd3, 3'd2}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CH_W-1:0]   chan,
  input  logic [DATA_W-1:0] code,
  input  logic [DATA_W-1:0] thresh,
  output logic [NMON-1:0]   flag
);
  logic hit;
  assign hit = $signed(code) >= $signed(thresh);

  for (genvar g = 0; g < NMON; g++) begin : g_mon
    logic prev_q, flag_q;
    logic mine;
    assign mine = load && (chan == MON_CHS[g*CH_W +: CH_W]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else if (mine) begin
        prev_q <= hit;
        if (hit == prev_q) flag_q <= hit;
      end
    end
    assign flag[g] = flag_q;
  end
endmodule

// File: rtl/adcseq_top.sv
`timescale 1ns/1ps
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int DATA_W   = SAMPLE_W,
  parameter int SETTLE_W = 16,
  parameter int DIV_W    = 8,
  parameter logic [NMON*CH_W-1:0] MON_CHS = {3'd3, 3'd2}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [NCH-1:0]      ch_en,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic [DATA_W-1:0]   disc_thresh,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic [CH_W-1:0]     adc_mux_sel,
  input  logic                adc_sdata,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [CH_W-1:0]     res_chan,
  output logic [DATA_W-1:0]   res_code,
  output logic [NMON-1:0]     disc_flag
);
  seq_state_t          state;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [CH_W-1:0]     last_ch, sel_q, next_ch;
  logic                any_en, rx_done, out_free, load;
  logic [DATA_W-1:0]   rx_word;

  adcseq_rr_pick #(.CH_W(CH_W)) u_pick (
    .last(last_ch), .en(ch_en), .any(any_en), .pick(next_ch)
  );

  adcseq_serial_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(state == ST_CONV), .div(clk_div),
    .sdata(adc_sdata), .sclk(adc_sclk), .done(rx_done), .word(rx_word)
  );

  assign out_free    = !res_valid || res_ready;
  assign load        = (state == ST_DONE) && out_free;
  assign adc_cs_n    = (state != ST_CONV);
  assign adc_mux_sel = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      settle_cnt <= '0;
      last_ch    <= CH_W'(NCH - 1);
      sel_q      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (run && any_en) begin
          sel_q      <= next_ch;
          last_ch    <= next_ch;
          settle_cnt <= settle_cycles;
          state      <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_cnt == '0) state <= ST_CONV;
          else settle_cnt <= settle_cnt - SETTLE_W'(1);
        end
        ST_CONV: if (rx_done) state <= ST_DONE;
        ST_DONE: if (out_free) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_code  <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_chan  <= sel_q;
      res_code  <= rx_word;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  adcseq_disc_track #(
    .NMON(NMON), .CH_W(CH_W), .DATA_W(DATA_W), .MON_CHS(MON_CHS)
  ) u_disc (
    .clk(clk), .rst_n(rst_n), .load(load), .chan(sel_q), .code(rx_word),
    .thresh(disc_thresh), .flag(disc_flag)
  );
endmodule

// File: rtl/adcseq_chk.sv
`timescale 1ns/1ps
module adcseq_chk
  import adcseq_pkg::*;
#(
  parameter int DATA_W   = SAMPLE_W,
  parameter int SETTLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH-1:0]      ch_en,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic                adc_cs_n,
  input logic                adc_sclk,
  input logic [CH_W-1:0]     adc_mux_sel,
  input logic                res_valid,
  input logic                res_ready,
  input logic [CH_W-1:0]     res_chan,
  input logic [DATA_W-1:0]   res_code
);
  logic [SETTLE_W:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!adc_cs_n) hi_cnt <= '0;
    else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_SEL_STABLE_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_mux_sel)); // R3
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_cnt >= {1'b0, settle_cycles} + 1'b1)); // R3
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk); // R4
  AST_CS_MIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |=> adc_cs_n); // R5
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_chan) && $stable(res_code))); // R6
  AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> ch_en[adc_mux_sel]); // R2
endmodule

bind adcseq_top adcseq_chk u_chk (.*);

// File: tb/tb_adcseq_top.sv
`timescale 1ns/1ps
module tb_adcseq_top;
  logic clk = 0, rst_n = 0, run = 0;
  logic [7:0]  ch_en = 0;
  logic [15:0] settle_cycles = 16;
  logic [7:0]  clk_div = 2;
  logic [11:0] disc_thresh = 12'h7F0;
  logic adc_sdata = 0, res_ready = 0;
  wire adc_cs_n, adc_sclk, res_valid;
  wire [2:0] adc_mux_sel, res_chan;
  wire [11:0] res_code;
  wire [1:0] disc_flag;

  adcseq_top dut (.*);

  always #2.5 clk = ~clk;

  int n_run = 0, n_bad = 0, got_words = 0;
  bit finished = 0;
  logic [11:0] code_tbl [8];
  logic [2:0]  exp_last = 3'd7;
  logic [1:0]  exp_flag = 0, exp_prev = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_next(input logic [2:0] last, input logic [7:0] en);
    for (int k = 1; k <= 8; k++) begin
      logic [2:0] c;
      c = last + 3'(k);
      if (en[c]) return c;
    end
    return last;
  endfunction

  // converter model: bit driven on each falling serial edge, MSB first
  logic [11:0] cur_code;
  int bit_idx = 0;
  always @(negedge adc_cs_n) begin
    cur_code = code_tbl[adc_mux_sel];
    bit_idx = 11;
  end
  always @(negedge adc_sclk) begin
    if (!adc_cs_n && bit_idx >= 0) begin
      adc_sdata <= cur_code[bit_idx];
      bit_idx--;
    end
  end

  task automatic take_word();
    logic [2:0] ec;
    ec = ref_next(exp_last, ch_en);
    check(res_chan == ec, "R2", "channel order", res_chan, ec);
    check(res_code == code_tbl[res_chan], "R4", "sampled code", res_code, code_tbl[res_chan]);
    exp_last = res_chan;
    for (int m = 0; m < 2; m++) begin
      if (res_chan == 3'(m + 2)) begin
        logic hit;
        hit = $signed(res_code) >= $signed(disc_thresh);
        if (hit == exp_prev[m]) exp_flag[m] = hit;
        exp_prev[m] = hit;
      end
    end
    got_words++;
  endtask

  // consumer with random back-pressure (R6)
  initial begin
    bit stall_prev = 0, rdy;
    logic [14:0] hold = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall_prev)
          check(res_valid && {res_chan, res_code} == hold, "R6", "stalled word",
                {res_valid, res_chan, res_code}, {1'b1, hold});
        rdy = ($urandom_range(0, 9) < 7);
        res_ready = rdy;
        stall_prev = res_valid && !rdy;
        hold = {res_chan, res_code};
        if (res_valid && rdy) take_word();
      end
    end
  end

  // pin timing monitor
  initial begin
    logic pcs = 1, psclk = 1;
    logic [2:0] pmux = 0;
    int gap = 0, rises = 0, hi_len = 0, div_eff;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        div_eff = (clk_div == 0) ? 1 : clk_div;
        if (adc_cs_n && !adc_sclk) check(0, "R4", "sclk idle level", adc_sclk, 1);
        if (pcs && !adc_cs_n) begin
          check(hi_len >= settle_cycles + 1, "R3", "settle gap", hi_len, settle_cycles + 1);
          gap = 0; rises = 0;
        end else if (!pcs) begin
          gap++;
          if (adc_mux_sel != pmux) check(0, "R3", "select moved in conversion", adc_mux_sel, pmux);
          if (adc_sclk != psclk) begin
            check(gap == div_eff, "R4", "sclk half period", gap, div_eff);
            gap = 0;
            if (adc_sclk) rises++;
          end else if (rises == 0 && gap == div_eff && adc_sclk) begin
            check(0, "R4", "first edge not falling", adc_sclk, 0);
          end
          if (adc_cs_n) check(rises == 12 && adc_sclk != psclk, "R5", "bits per frame", rises, 12);
        end
        hi_len = adc_cs_n ? hi_len + 1 : 0;
        pcs = adc_cs_n; psclk = adc_sclk; pmux = adc_mux_sel;
      end
    end
  end

  task automatic run_phase(input int words);
    int start, lim;
    start = got_words;
    run = 1;
    lim = 0;
    while (got_words < start + words && lim < 30000) begin @(negedge clk); lim++; end
    check(got_words >= start + words, "R2", "scan progress", got_words - start, words);
    run = 0;
    repeat (settle_cycles + 30 * (clk_div + 1) + 60) @(negedge clk);
    lim = 0;
    while (res_valid && lim < 200) begin @(negedge clk); lim++; end
    check(adc_cs_n && !res_valid, "R8", "quiet after stop", {adc_cs_n, res_valid}, 2'b10);
    check(disc_flag == exp_flag, "R7", "disconnect flags", disc_flag, exp_flag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) code_tbl[i] = 12'($urandom);
    repeat (5) @(negedge clk);
    check(adc_cs_n == 1 && adc_sclk == 1, "R1", "reset cs/sclk", {adc_cs_n, adc_sclk}, 2'b11);
    check(adc_mux_sel == 0, "R1", "reset select", adc_mux_sel, 0);
    check(res_valid == 0 && disc_flag == 0, "R1", "reset outputs", {res_valid, disc_flag}, 0);
    rst_n = 1;
    ch_en = 8'hFF;
    repeat (50) @(negedge clk);
    check(adc_cs_n == 1 && got_words == 0, "R8", "run low stays idle", got_words, 0);

    for (int p = 0; p < 12; p++) begin
      case (p)
        0: begin
          ch_en = 8'h0D; clk_div = 2; settle_cycles = 16; disc_thresh = 12'h7F0;
          code_tbl[2] = 12'h7FF; code_tbl[3] = 12'h7EF;
          run_phase(6);
          check(disc_flag == 2'b01, "R7", "full scale sets flag", disc_flag, 2'b01);
        end
        1: begin
          code_tbl[2] = 12'h800;
          run_phase(6);
          check(disc_flag == 2'b00, "R7", "negative code clears flag", disc_flag, 2'b00);
        end
        2: begin
          ch_en = 8'h00;
          run = 1;
          begin
            int low = 0;
            repeat (300) begin @(negedge clk); if (!adc_cs_n) low++; end
            check(low == 0, "R8", "empty mask no conversion", low, 0);
          end
          run = 0;
        end
        3: begin
          ch_en = 8'h80; clk_div = 1; settle_cycles = 0;
          run_phase(4);
        end
        4: begin
          ch_en = 8'h08; disc_thresh = 12'h000; code_tbl[3] = 12'h000; clk_div = 0;
          run_phase(3);
          check(disc_flag[1] == 1'b1, "R7", "equal to threshold is hit", disc_flag[1], 1);
        end
        default: begin
          ch_en = 8'($urandom_range(1, 255));
          clk_div = 8'($urandom_range(1, 4));
          settle_cycles = 16'($urandom_range(0, 24));
          disc_thresh = 12'($urandom);
          for (int i = 0; i < 8; i++) code_tbl[i] = 12'($urandom);
          if (p % 2 == 0) code_tbl[2] = 12'h7FF;
          run_phase($urandom_range(4, 8));
        end
      endcase
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule